// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of an 8-bit successive-approximation converter. It divides the system clock down to a conversion tick and walks a binary search across the code range, one bit per tick. On each tick it reads a single comparator bit, which is high when the held analog sample is above the level of the external DAC. The code it is trying is driven straight to that DAC.

A conversion starts at mid-scale. After eight ticks the block latches the final code and raises a one-clock ready pulse that can feed an interrupt line. It then begins the next conversion, opening with a one-clock strobe that tells the analog front end to take a new sample.

While the enable input is low, the divider and the search logic are held in their idle state, which has the same effect as gating their clock. A conversion that is cut off by a low enable is dropped, and the last result stays in place. The division ratio is taken from the input at the start of each conversion and holds until that conversion ends.

Top module: `sar_sequencer`

## Requirements
- R1: While reset is asserted and immediately after it, `dacCode` is 0x80, `result` is 0x00, and `busy`, `sampleHold` and `dataReady` are all 0.
- R2: In the clock after `enable` is seen high with `busy` low, `busy` is 1, `sampleHold` is 1 and `dacCode` is 0x80. `sampleHold` is 1 for exactly that one clock.
- R3: The conversion tick comes every `clkDiv`+1 clocks. `clkDiv` is captured in the clock in which the conversion starts, and a later change to it does not alter that conversion. If `busy` rises in clock 0, `dataReady` is 1 in clock 8·(D+1), where D is the captured value, and 0 in every clock before it.
- R4: On each tick that is not the last, the bit under trial is kept at 1 when `cmpHigh` is 1 and cleared otherwise, and the next lower bit is set. For example, one clock after the first tick `dacCode` is 0xC0 if the sample is above 0x80 and 0x40 if it is not.
- R5: On the last tick, `result` is loaded with the upper seven trial bits and an LSB equal to `cmpHigh`. For a constant sample this is the largest code c for which the sample is above level c, or 0 if there is no such code.
- R6: `dataReady` is high for exactly one clock, and `busy` is 0 in that clock. If `enable` is still high, the next conversion starts in the following clock with `busy` and `sampleHold` high.
- R7: A sample equal to 0.51/1.2 of full scale produces the result 0x6C.
- R8: When `enable` is low, the conversion in progress is dropped. In the next clock `busy` is 0, `dacCode` is 0x80 and `dataReady` stays 0. `result` is not changed, and a later enable starts a fresh conversion from 0x80.
- R9: `result` changes only in a clock in which `dataReady` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Converter run control; low holds the block idle |
| clkDiv | input | 8 | Tick period minus one, in system clocks |
| cmpHigh | input | 1 | Comparator: held sample above DAC level |
| dacCode | output | 8 | Trial code driven to the DAC |
| result | output | 8 | Latched conversion result |
| busy | output | 1 | Conversion in progress |
| sampleHold | output | 1 | One-clock strobe to capture a new sample |
| dataReady | output | 1 | One-clock pulse when a new result is written |

## Verification
The bench builds the block with its default parameters: 8-bit resolution and an 8-bit divider. This makes the whole code range reachable, including both rails and the two codes on either side of mid-scale, and it allows divider values from 0 up to 255. The bench contains a comparator model that holds the sample on the strobe. Against it, random sample levels and divider values run alongside directed cases: the 0.51 V point, a divider change part way through a conversion, and a conversion cut off by a low enable.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  // Strobes from the control unit to the search datapath
  typedef struct packed {
    logic startConv;   // a new conversion opens this clock
    logic stepBit;     // tick that resolves a bit other than the LSB
    logic finishConv;  // tick that resolves the LSB and latches the result
    logic abortConv;   // converter disabled: return to the idle state
  } seqStrobes_t;

endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int RES_BITS = 8,
  parameter int DIV_W    = 8,
  localparam int IDX_W   = $clog2(RES_BITS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [DIV_W-1:0] clkDiv,
  output seqStrobes_t      strobes,
  output logic [IDX_W-1:0] bitIdx,
  output logic             busy,
  output logic             sampleHold
);

  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(RES_BITS - 1);

  logic [DIV_W-1:0] divLatch;
  logic [DIV_W-1:0] divCnt;
  logic             tick;

  assign tick = enable && busy && (divCnt == divLatch);

  always_comb begin
    strobes.abortConv  = !enable;
    strobes.startConv  = enable && !busy;
    strobes.stepBit    = tick && (bitIdx != '0);
    strobes.finishConv = tick && (bitIdx == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy       <= 1'b0;
      sampleHold <= 1'b0;
      divCnt     <= '0;
      divLatch   <= '0;
      bitIdx     <= TOP_IDX;
    end else if (!enable) begin
      busy       <= 1'b0;
      sampleHold <= 1'b0;
      divCnt     <= '0;
      bitIdx     <= TOP_IDX;
    end else if (!busy) begin
      busy       <= 1'b1;
      sampleHold <= 1'b1;
      divCnt     <= '0;
      divLatch   <= clkDiv;
      bitIdx     <= TOP_IDX;
    end else begin
      sampleHold <= 1'b0;
      if (tick) begin
        divCnt <= '0;
        if (bitIdx == '0) begin
          busy   <= 1'b0;
          bitIdx <= TOP_IDX;
        end else begin
          bitIdx <= bitIdx - 1'b1;
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  AST_HOLD_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    sampleHold |=> !sampleHold) else $error("hold strobe longer than one clock"); // R2
  AST_HOLD_WITH_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    sampleHold |-> (busy && bitIdx == TOP_IDX)) else $error("hold strobe outside conversion start"); // R2
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (divCnt <= divLatch)) else $error("divider count past its limit"); // R3
  AST_DIV_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(divLatch)) else $error("divider moved mid conversion"); // R3

endmodule

// File: rtl/sar_seq_datapath.sv
module sar_seq_datapath
  import sar_seq_pkg::*;
#(
  parameter int RES_BITS = 8,
  localparam int IDX_W   = $clog2(RES_BITS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobes_t         strobes,
  input  logic [IDX_W-1:0]    bitIdx,
  input  logic                cmpHigh,
  output logic [RES_BITS-1:0] trialCode,
  output logic [RES_BITS-1:0] resultCode,
  output logic                readyPulse
);

  localparam logic [RES_BITS-1:0] MID_CODE = RES_BITS'(1) << (RES_BITS - 1);

  logic [RES_BITS-1:0] steppedTrial;

  // Resolve the current bit and arm the next lower one
  always_comb begin
    for (int i = 0; i < RES_BITS; i++) begin
      if (i == int'(bitIdx))          steppedTrial[i] = cmpHigh;
      else if (i == int'(bitIdx) - 1) steppedTrial[i] = 1'b1;
      else                            steppedTrial[i] = trialCode[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trialCode  <= MID_CODE;
      resultCode <= '0;
      readyPulse <= 1'b0;
    end else if (strobes.abortConv) begin
      trialCode  <= MID_CODE;
      readyPulse <= 1'b0;
    end else if (strobes.finishConv) begin
      resultCode <= {trialCode[RES_BITS-1:1], cmpHigh};
      trialCode  <= MID_CODE;
      readyPulse <= 1'b1;
    end else begin
      if (strobes.stepBit) trialCode <= steppedTrial;
      readyPulse <= 1'b0;
    end
  end

  AST_START_AT_MID: assert property (@(posedge clk) disable iff (!rstN)
    strobes.startConv |-> (trialCode == MID_CODE)) else $error("conversion opened off mid-scale"); // R2
  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    readyPulse |=> !readyPulse) else $error("ready pulse too long"); // R6
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !readyPulse |-> $stable(resultCode)) else $error("result moved without ready"); // R9
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.startConv, strobes.stepBit, strobes.finishConv, strobes.abortConv}))
    else $error("conflicting strobes"); // R4

endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
  import sar_seq_pkg::*;
#(
  parameter int RES_BITS = 8,
  parameter int DIV_W    = 8,
  localparam int IDX_W   = $clog2(RES_BITS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic [DIV_W-1:0]    clkDiv,
  input  logic                cmpHigh,
  output logic [RES_BITS-1:0] dacCode,
  output logic [RES_BITS-1:0] result,
  output logic                busy,
  output logic                sampleHold,
  output logic                dataReady
);

  seqStrobes_t      strobes;
  logic [IDX_W-1:0] bitIdx;

  sar_seq_ctrl #(.RES_BITS(RES_BITS), .DIV_W(DIV_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .clkDiv     (clkDiv),
    .strobes    (strobes),
    .bitIdx     (bitIdx),
    .busy       (busy),
    .sampleHold (sampleHold)
  );

  sar_seq_datapath #(.RES_BITS(RES_BITS)) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .bitIdx     (bitIdx),
    .cmpHigh    (cmpHigh),
    .trialCode  (dacCode),
    .resultCode (result),
    .readyPulse (dataReady)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!busy && !dataReady)) else $error("activity while disabled"); // R8
  AST_READY_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    dataReady |-> !busy) else $error("busy during ready clock"); // R6

endmodule

// File: tb/sar_sequencer_bench.sv
module sar_sequencer_bench;

  localparam int SCALE = 16;  // sample units per code step

  logic       clk = 1'b0;
  logic       rstN;
  logic       enable;
  logic [7:0] clkDiv;
  logic       cmpHigh;
  logic [7:0] dacCode;
  logic [7:0] result;
  logic       busy;
  logic       sampleHold;
  logic       dataReady;

  int vinLive;
  int vinHeld;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sar_sequencer u_sar_sequencer (
    .clk(clk), .rstN(rstN), .enable(enable), .clkDiv(clkDiv), .cmpHigh(cmpHigh),
    .dacCode(dacCode), .result(result), .busy(busy), .sampleHold(sampleHold),
    .dataReady(dataReady)
  );

  // Sample-and-hold plus comparator model
  always_ff @(posedge clk) if (sampleHold) vinHeld <= vinLive;
  assign cmpHigh = ((sampleHold ? vinLive : vinHeld) > int'(dacCode) * SCALE);

  function automatic int expectCode(input int vin);
    for (int c = 255; c >= 0; c--) if (c * SCALE < vin) return c;
    return 0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Starts from idle with enable low; ends idle with enable low
  task automatic runConv(input int vin, input int div, input int newDiv);
    int exp = expectCode(vin);
    int last = 8 * (div + 1);
    vinLive = vin; clkDiv = 8'(div); enable = 1'b1;
    @(negedge clk);
    check("R2 busy at start", int'(busy), 1);
    check("R2 hold strobe", int'(sampleHold), 1);
    check("R2 dac mid-scale", int'(dacCode), 8'h80);
    for (int k = 1; k <= last + 1; k++) begin
      if (k == 1) clkDiv = 8'(newDiv);
      @(negedge clk);
      if (k == 1 && last > 1) check("R2 hold one clock", int'(sampleHold), 0);
      if (k == div + 1) check("R4 first step", int'(dacCode), (vin > 128 * SCALE) ? 8'hC0 : 8'h40);
      if (k == last - 1) begin
        check("R3 not ready early", int'(dataReady), 0);
        check("R3 busy before end", int'(busy), 1);
      end
      if (k == last) begin
        check("R3 ready timing", int'(dataReady), 1);
        check("R6 busy low at ready", int'(busy), 0);
        check("R5 result", int'(result), exp);
      end
      if (k == last + 1) begin
        check("R6 ready single", int'(dataReady), 0);
        check("R6 restart busy", int'(busy), 1);
        check("R6 restart hold", int'(sampleHold), 1);
      end
    end
    enable = 1'b0; clkDiv = 8'(div);
    @(negedge clk);
    check("R8 idle busy", int'(busy), 0);
    check("R8 idle dac", int'(dacCode), 8'h80);
    check("R9 result kept", int'(result), exp);
  endtask

  initial begin
    int seen;
    void'($urandom(32'd20240611));
    rstN = 1'b0; enable = 1'b0; clkDiv = 8'd0; vinLive = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 dac", int'(dacCode), 8'h80);
    check("R1 result", int'(result), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 hold", int'(sampleHold), 0);
    check("R1 ready", int'(dataReady), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", int'(busy), 0);

    // R7: 0.51 V of 1.2 V full scale
    runConv(1741, 3, 3);
    check("R7 0.51V code", int'(result), 8'h6C);

    // R8: drop enable mid conversion, then restart
    vinLive = 300; clkDiv = 8'd1; enable = 1'b1;
    repeat (6) @(negedge clk);
    enable = 1'b0;
    seen = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (dataReady) seen++;
    end
    check("R8 no ready after abort", seen, 0);
    check("R8 busy after abort", int'(busy), 0);
    check("R8 dac after abort", int'(dacCode), 8'h80);
    check("R8 result untouched", int'(result), 8'h6C);
    runConv(300, 1, 1);

    // Corners: rails, around mid-scale, divider extremes, divider change (R3)
    runConv(0, 0, 0);
    runConv(5000, 0, 4);
    runConv(2048, 2, 7);
    runConv(2049, 5, 0);
    runConv(1000, 255, 3);

    for (int n = 0; n < 24; n++) begin
      runConv(int'($urandom_range(0, 4200)), int'($urandom_range(0, 6)),
              int'($urandom_range(0, 6)));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule